// File: doc/BRIEF.md
# Parallel Camera Capture with Crop Window

This block takes pixels from a parallel image sensor and keeps only a rectangular region of each frame. The sensor supplies a pixel clock, a 14-bit data bus, and separate line and frame sync lines. All of these are sampled in one system clock. The pixel clock is edge-detected inside the block and acts as a pixel strobe. Configuration selects which edge of the pixel clock carries data, and which level of each sync line means blanking.

Inside a frame, the block counts lines and pixels. A pixel is accepted when its line index and its pixel index both fall inside the crop window. Accepted pixels are zero-extended to 16 bits, and two of them are packed into each 32-bit word. Words go into a four-entry FIFO. A DMA request is held high while DMA is enabled and the FIFO holds at least one word.

Capture starts and stops only during frame blanking, so a frame is never captured in part. Stopping capture empties the FIFO.

Top module: `cam_crop_capture`

## Requirements
- R1: After reset the FIFO is empty (`fifo_empty`=1, `fifo_level`=0), and `dma_req` and `ovf_flag` are 0.
- R2: When `cfg_rise_edge`=1, data is sampled on rising edges of `pix_clk`. When it is 0, data is sampled on falling edges.
- R3: A sample is a valid pixel only when `hsync` differs from `cfg_hs_blank_hi` and `vsync` differs from `cfg_vs_blank_hi`. Samples taken during either kind of blanking are never stored.
- R4: Within a frame, line index 0 is the first line after frame blanking, and pixel index 0 is the first valid pixel of a line. A pixel is stored only if its line index is in [`cfg_line_start`, `cfg_line_start`+`cfg_line_span_m1`] and its pixel index is in [`cfg_pix_start`, `cfg_pix_start`+`cfg_pix_span_m1`].
- R5: Stored pixels are paired in arrival order. The first pixel of a pair goes in bits 13:0 and the second in bits 29:16. Bits 15:14 and 31:30 are 0.
- R6: The FIFO holds up to 4 words. `fifo_rdata` shows the oldest word. A cycle with `fifo_rd`=1 and a non-empty FIFO removes that word. `fifo_level` gives the number of words held.
- R7: A word that arrives while the FIFO is full, with no read in the same cycle, is dropped and sets `ovf_flag`. The flag stays set until `ovf_clr` is pulsed.
- R8: `dma_req` is 1 exactly when `dma_en`=1 and the FIFO is not empty.
- R9: While `cfg_embed_sync`=1, no pixel is stored.
- R10: A change of `cap_en` takes effect only at a pixel-clock sample taken during frame blanking. Once capture has stopped, the FIFO is empty.
- R11: When a frame ends with an odd number of stored pixels, the unpaired pixel is discarded. It never appears in a word of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_en | input | 1 | Capture enable, applied at frame blanking |
| cfg_embed_sync | input | 1 | Sync source select; 1 disables storing pixels |
| cfg_rise_edge | input | 1 | 1 = sample on rising pixel-clock edge, 0 = falling |
| cfg_hs_blank_hi | input | 1 | Level of `hsync` during line blanking |
| cfg_vs_blank_hi | input | 1 | Level of `vsync` during frame blanking |
| cfg_line_start | input | 14 | First line of the crop window |
| cfg_pix_start | input | 14 | First pixel of the crop window |
| cfg_line_span_m1 | input | 14 | Crop window height minus one |
| cfg_pix_span_m1 | input | 14 | Crop window width minus one |
| dma_en | input | 1 | Enables the DMA request |
| ovf_clr | input | 1 | Clears the overflow flag |
| pix_clk | input | 1 | Sensor pixel clock, sampled by `clk` |
| pix_data | input | 14 | Sensor pixel data |
| hsync | input | 1 | Line sync |
| vsync | input | 1 | Frame sync |
| fifo_rd | input | 1 | Removes the oldest FIFO word |
| fifo_rdata | output | 32 | Oldest FIFO word |
| fifo_level | output | 3 | Number of words in the FIFO |
| fifo_empty | output | 1 | FIFO holds no word |
| dma_req | output | 1 | DMA request |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The main sweep runs a small frame of 4 lines by 6 pixels through every crop start and span combination that fits. It repeats these under all four combinations of sync blanking polarity, alternating the capture edge from frame to frame. Each pixel changes its data between the rising and the falling edge, so a word shows which edge was used. Each pixel value encodes its line and column, so a wrong crop boundary shows up as a wrong word. Blanking samples carry marker values that must never appear in a word.

Windows with an odd pixel count, followed directly by another frame, show whether a leftover half-word leaks into the next frame. Directed frames cover the following:
- overflow with the FIFO left unread;
- clearing the overflow flag, and the DMA request following the FIFO;
- the embedded-sync mode bit;
- `cap_en` toggled in the middle of a frame, which separates an enable that applies at once from one that waits for blanking.

// File: rtl/cam_pkg.sv
// Shared widths and the per-sample record of the camera capture block.
package cam_pkg;
    localparam int PIX_W  = 14;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    // One pixel-clock sample after polarity decoding.
    typedef struct packed {
        logic             in_frame;
        logic             in_line;
        logic [PIX_W-1:0] data;
    } cam_sample_t;
endpackage

// File: rtl/cam_sampler.sv
// Pixel-clock edge detector and sync decoder.
// Assumes pix_clk, pix_data and the syncs are already synchronous to clk, and
// that each pix_clk level lasts at least one clk cycle. strobe is high for one
// cycle at the selected edge; smp carries the data and decoded sync states.
module cam_sampler
    import cam_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_rise_edge,
    input  logic             cfg_hs_blank_hi,
    input  logic             cfg_vs_blank_hi,
    input  logic             pix_clk,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             hsync,
    input  logic             vsync,
    output logic             strobe,
    output cam_sample_t      smp
);
    logic pclk_q;

    // Keep the previous pixel-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pclk_q <= 1'b0;
        else        pclk_q <= pix_clk;
    end

    // Select the active edge and decode the sync lines against their blanking level.
    always_comb begin
        strobe       = cfg_rise_edge ? (pix_clk & ~pclk_q) : (~pix_clk & pclk_q);
        smp.in_line  = hsync ^ cfg_hs_blank_hi;
        smp.in_frame = vsync ^ cfg_vs_blank_hi;
        smp.data     = pix_data;
    end
endmodule

// File: rtl/cam_window.sv
// Capture gating, line/pixel position counters and the crop-window test.
// Capture on/off is latched only on a strobe taken in frame blanking. Counters
// are cleared while capture is off. Outputs are registered one cycle after the
// strobe: acc_v marks a pixel to store, gap_v marks a frame-blanking sample.
module cam_window
    import cam_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  cam_sample_t      smp,
    input  logic             cap_en,
    input  logic             cfg_embed_sync,
    input  logic [CNT_W-1:0] cfg_line_start,
    input  logic [CNT_W-1:0] cfg_pix_start,
    input  logic [CNT_W-1:0] cfg_line_span_m1,
    input  logic [CNT_W-1:0] cfg_pix_span_m1,
    output logic             run,
    output logic             acc_v,
    output logic [PIX_W-1:0] acc_d,
    output logic             gap_v
);
    logic [CNT_W-1:0] line_cnt, pix_cnt;
    logic             prev_valid;
    logic             valid, in_win;
    logic [CNT_W:0]   line_end, pix_end;

    // Saturating increment keeps a long line from wrapping back into the window.
    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    // Compute the valid-pixel flag and the inclusive window bounds.
    always_comb begin
        valid    = smp.in_frame & smp.in_line;
        line_end = {1'b0, cfg_line_start} + {1'b0, cfg_line_span_m1};
        pix_end  = {1'b0, cfg_pix_start} + {1'b0, cfg_pix_span_m1};
        in_win   = ({1'b0, line_cnt} >= {1'b0, cfg_line_start}) &&
                   ({1'b0, line_cnt} <= line_end) &&
                   ({1'b0, pix_cnt} >= {1'b0, cfg_pix_start}) &&
                   ({1'b0, pix_cnt} <= pix_end);
    end

    // Latch the capture enable only at frame-blanking samples.
    always_ff @(posedge clk) begin
        if (!rst_n)                          run <= 1'b0;
        else if (strobe && !smp.in_frame)    run <= cap_en;
    end

    // Track the line and pixel index of each sample within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            line_cnt   <= '0;
            pix_cnt    <= '0;
            prev_valid <= 1'b0;
        end else if (strobe) begin
            prev_valid <= valid;
            if (!smp.in_frame) begin
                line_cnt <= '0;
                pix_cnt  <= '0;
            end else if (smp.in_line) begin
                pix_cnt  <= sat_inc(pix_cnt);
            end else begin
                pix_cnt  <= '0;
                if (prev_valid) line_cnt <= sat_inc(line_cnt);
            end
        end
    end

    // Register the store decision and the frame-gap marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_v <= 1'b0;
            gap_v <= 1'b0;
            acc_d <= '0;
        end else begin
            acc_v <= strobe & run & valid & in_win & ~cfg_embed_sync;
            gap_v <= strobe & ~smp.in_frame;
            acc_d <= smp.data;
        end
    end

    AST_EMBED_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_embed_sync && $past(cfg_embed_sync)) |-> !acc_v); // R9
    AST_RUN_AT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (run != $past(run)) |-> $past(strobe && !smp.in_frame)); // R10
endmodule

// File: rtl/cam_pack_fifo.sv
// Pairs 14-bit pixels into 32-bit words and buffers them in a small FIFO.
// Assumes DEPTH is a power of two. A half-filled word is discarded at frame
// blanking. The whole store is cleared while capture is off. The overflow flag
// is sticky and cleared only by ovf_clr.
module cam_pack_fifo
    import cam_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int LVL_W = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              acc_v,
    input  logic [PIX_W-1:0]  acc_d,
    input  logic              gap_v,
    input  logic              rd,
    input  logic              ovf_clr,
    output logic [WORD_W-1:0] rdata,
    output logic [LVL_W-1:0]  level,
    output logic              empty,
    output logic              ovf
);
    localparam int PADW = HALF_W - PIX_W;

    logic [PIX_W-1:0]  half_q;
    logic              half_v;
    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic              push, pop, full, wr_ok;
    logic [WORD_W-1:0] word;

    // Decode the push, pop and full conditions and form the packed word.
    always_comb begin
        empty = (level == '0);
        full  = (level == LVL_W'(DEPTH));
        pop   = rd & ~empty;
        push  = run & acc_v & half_v;
        wr_ok = push & (~full | pop);
        word  = {{PADW{1'b0}}, acc_d, {PADW{1'b0}}, half_q};
        rdata = mem[rp];
    end

    // Hold the first pixel of each pair; drop it at frame blanking.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            half_v <= 1'b0;
            half_q <= '0;
        end else if (gap_v) begin
            half_v <= 1'b0;
        end else if (acc_v) begin
            half_v <= ~half_v;
            if (!half_v) half_q <= acc_d;
        end
    end

    // Word storage; entries need no reset.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= word;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (wr_ok) wp <= wp + 1'b1;
            if (pop)   rp <= rp + 1'b1;
            level <= level + LVL_W'(wr_ok) - LVL_W'(pop);
        end
    end

    // Sticky overflow flag: a drop sets it and takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ovf <= 1'b0;
        else if (push && !wr_ok)    ovf <= 1'b1;
        else if (ovf_clr)           ovf <= 1'b0;
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf); // R7
    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && acc_v && half_v && full && !rd) |=> ovf); // R7
    AST_STOP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |=> empty); // R10
endmodule

// File: rtl/cam_crop_capture.sv
// Top level of the parallel camera capture block: sampler, crop window and
// packing FIFO, plus the DMA request. One clock domain is assumed.
module cam_crop_capture
    import cam_pkg::*;
#(
    parameter int CNT_W      = 14,
    parameter int FIFO_DEPTH = 4,
    localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              cfg_embed_sync,
    input  logic              cfg_rise_edge,
    input  logic              cfg_hs_blank_hi,
    input  logic              cfg_vs_blank_hi,
    input  logic [CNT_W-1:0]  cfg_line_start,
    input  logic [CNT_W-1:0]  cfg_pix_start,
    input  logic [CNT_W-1:0]  cfg_line_span_m1,
    input  logic [CNT_W-1:0]  cfg_pix_span_m1,
    input  logic              dma_en,
    input  logic              ovf_clr,
    input  logic              pix_clk,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              fifo_rd,
    output logic [WORD_W-1:0] fifo_rdata,
    output logic [LVL_W-1:0]  fifo_level,
    output logic              fifo_empty,
    output logic              dma_req,
    output logic              ovf_flag
);
    logic             strobe, run, acc_v, gap_v;
    cam_sample_t      smp;
    logic [PIX_W-1:0] acc_d;

    cam_sampler u_sampler (
        .clk(clk), .rst_n(rst_n),
        .cfg_rise_edge(cfg_rise_edge),
        .cfg_hs_blank_hi(cfg_hs_blank_hi), .cfg_vs_blank_hi(cfg_vs_blank_hi),
        .pix_clk(pix_clk), .pix_data(pix_data), .hsync(hsync), .vsync(vsync),
        .strobe(strobe), .smp(smp)
    );

    cam_window #(.CNT_W(CNT_W)) u_window (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .smp(smp),
        .cap_en(cap_en), .cfg_embed_sync(cfg_embed_sync),
        .cfg_line_start(cfg_line_start), .cfg_pix_start(cfg_pix_start),
        .cfg_line_span_m1(cfg_line_span_m1), .cfg_pix_span_m1(cfg_pix_span_m1),
        .run(run), .acc_v(acc_v), .acc_d(acc_d), .gap_v(gap_v)
    );

    cam_pack_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .run(run),
        .acc_v(acc_v), .acc_d(acc_d), .gap_v(gap_v),
        .rd(fifo_rd), .ovf_clr(ovf_clr),
        .rdata(fifo_rdata), .level(fifo_level), .empty(fifo_empty), .ovf(ovf_flag)
    );

    // DMA request follows FIFO occupancy while enabled.
    always_comb dma_req = dma_en & ~fifo_empty;

    AST_DMA_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (fifo_level != '0)); // R8
endmodule

// File: tb/tb_cam_crop_capture.sv
module tb_cam_crop_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_en = 1'b0, cfg_embed_sync = 1'b0, cfg_rise_edge = 1'b1;
    logic        cfg_hs_blank_hi = 1'b1, cfg_vs_blank_hi = 1'b1;
    logic [13:0] cfg_line_start = '0, cfg_pix_start = '0;
    logic [13:0] cfg_line_span_m1 = '0, cfg_pix_span_m1 = '0;
    logic        dma_en = 1'b0, ovf_clr = 1'b0, pix_clk = 1'b0;
    logic [13:0] pix_data = '0;
    logic        hsync = 1'b1, vsync = 1'b1, fifo_rd = 1'b0;
    logic [31:0] fifo_rdata;
    logic [2:0]  fifo_level;
    logic        fifo_empty, dma_req, ovf_flag;

    int checks = 0;
    int fails  = 0;
    logic [31:0] expw [0:15];
    int nexp;

    cam_crop_capture dut (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cfg_embed_sync(cfg_embed_sync),
        .cfg_rise_edge(cfg_rise_edge), .cfg_hs_blank_hi(cfg_hs_blank_hi),
        .cfg_vs_blank_hi(cfg_vs_blank_hi), .cfg_line_start(cfg_line_start),
        .cfg_pix_start(cfg_pix_start), .cfg_line_span_m1(cfg_line_span_m1),
        .cfg_pix_span_m1(cfg_pix_span_m1), .dma_en(dma_en), .ovf_clr(ovf_clr),
        .pix_clk(pix_clk), .pix_data(pix_data), .hsync(hsync), .vsync(vsync),
        .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata), .fifo_level(fifo_level),
        .fifo_empty(fifo_empty), .dma_req(dma_req), .ovf_flag(ovf_flag)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One pixel: data a around the rising edge, data b around the falling edge.
    task automatic pixel(input bit line_act, input bit frame_act,
                         input logic [13:0] a, input logic [13:0] b);
        @(negedge clk);
        hsync    = line_act  ? ~cfg_hs_blank_hi : cfg_hs_blank_hi;
        vsync    = frame_act ? ~cfg_vs_blank_hi : cfg_vs_blank_hi;
        pix_data = a;
        @(negedge clk); pix_clk = 1'b1;
        @(negedge clk);
        @(negedge clk); pix_data = b;
        @(negedge clk); pix_clk = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [13:0] pval(input logic [13:0] seed, input int l, input int p);
        return seed + 14'(l * 8 + p);
    endfunction

    // Frame of nl lines by np pixels; en_set >= 0 changes cap_en after the lead-in.
    task automatic frame(input int nl, input int np, input logic [13:0] seed,
                         input int tail, input int en_set);
        pixel(0, 0, 14'h3FFF, 14'h3FFF);
        pixel(1, 0, 14'h3FFD, 14'h3FFD);
        pixel(0, 0, 14'h3FFF, 14'h3FFF);
        if (en_set >= 0) cap_en = en_set[0];
        for (int l = 0; l < nl; l++) begin
            for (int p = 0; p < np; p++)
                pixel(1, 1, pval(seed, l, p), pval(seed, l, p) ^ 14'h2000);
            pixel(0, 1, 14'h3FFE, 14'h3FFE);
            pixel(0, 1, 14'h3FFE, 14'h3FFE);
        end
        for (int t = 0; t < tail; t++) pixel(0, 0, 14'h3FFF, 14'h3FFF);
    endtask

    // Expected words from the crop window, pairing in arrival order (R4, R5, R11).
    task automatic build_exp(input int ls, input int lh, input int ps, input int pw,
                             input logic [13:0] seed, input bit rise);
        logic [13:0] first = '0;
        bit have = 1'b0;
        nexp = 0;
        for (int l = ls; l <= ls + lh; l++)
            for (int p = ps; p <= ps + pw; p++) begin
                logic [13:0] v = rise ? pval(seed, l, p) : (pval(seed, l, p) ^ 14'h2000);
                if (have) begin
                    if (nexp < 16) expw[nexp] = {2'b00, v, 2'b00, first};
                    nexp++;
                    have = 1'b0;
                end else begin
                    first = v;
                    have  = 1'b1;
                end
            end
    endtask

    task automatic drain(input string req);
        int k = 0;
        while (fifo_empty == 1'b0 && k < 16) begin
            if (k < nexp) chk(req, fifo_rdata, expw[k]);
            fifo_rd = 1'b1;
            @(negedge clk);
            fifo_rd = 1'b0;
            k++;
        end
        chk({req, " word count"}, 32'(k), 32'(nexp));
    endtask

    task automatic set_win(input int ls, input int lh, input int ps, input int pw);
        cfg_line_start   = 14'(ls);
        cfg_line_span_m1 = 14'(lh);
        cfg_pix_start    = 14'(ps);
        cfg_pix_span_m1  = 14'(pw);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int fidx = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 empty", 32'(fifo_empty), 32'd1);
        chk("R1 level", 32'(fifo_level), 32'd0);
        chk("R1 dma_req", 32'(dma_req), 32'd0);
        chk("R1 ovf", 32'(ovf_flag), 32'd0);

        // R10: capture disabled, frame leaves FIFO empty
        set_win(0, 0, 0, 5);
        frame(4, 6, 14'h0100, 1, -1);
        chk("R10 disabled frame level", 32'(fifo_level), 32'd0);

        // R10: enable raised mid-frame does not capture that frame
        frame(4, 6, 14'h0200, 0, 1);
        chk("R10 mid-frame enable level", 32'(fifo_level), 32'd0);
        frame(4, 6, 14'h0300, 1, -1);
        build_exp(0, 0, 0, 5, 14'h0300, 1'b1);
        drain("R10 frame after enable");

        // Sweep: R2 R3 R4 R5 R6 R11 over polarity, edge and windows
        for (int pol = 0; pol < 4; pol++) begin
            cfg_hs_blank_hi = pol[0];
            cfg_vs_blank_hi = pol[1];
            for (int ls = 0; ls < 3; ls++)
                for (int lh = 0; lh < 2; lh++)
                    for (int ps = 0; ps < 4; ps++)
                        for (int pw = 0; pw < 3; pw++) begin
                            logic [13:0] seed = 14'(fidx * 37);
                            cfg_rise_edge = fidx[0];
                            set_win(ls, lh, ps, pw);
                            frame(4, 6, seed, 0, -1);
                            build_exp(ls, lh, ps, pw, seed, fidx[0]);
                            drain("R2/R3/R4/R5/R11 sweep");
                            fidx++;
                        end
        end

        // R6 R7 R8: overflow with full window and no reads
        cfg_hs_blank_hi = 1'b1;
        cfg_vs_blank_hi = 1'b1;
        cfg_rise_edge   = 1'b1;
        dma_en          = 1'b1;
        set_win(0, 3, 0, 5);
        frame(4, 6, 14'h0400, 1, -1);
        chk("R6 level at full", 32'(fifo_level), 32'd4);
        chk("R7 ovf set", 32'(ovf_flag), 32'd1);
        chk("R8 dma_req with data", 32'(dma_req), 32'd1);
        dma_en = 1'b0;
        @(negedge clk);
        chk("R8 dma_req disabled", 32'(dma_req), 32'd0);
        build_exp(0, 3, 0, 5, 14'h0400, 1'b1);
        nexp = 4;
        drain("R6 oldest words kept");
        chk("R7 ovf sticky", 32'(ovf_flag), 32'd1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        @(negedge clk);
        chk("R7 ovf cleared", 32'(ovf_flag), 32'd0);
        dma_en = 1'b1;
        @(negedge clk);
        chk("R8 dma_req empty", 32'(dma_req), 32'd0);
        dma_en = 1'b0;

        // R9: embedded mode stores nothing
        cfg_embed_sync = 1'b1;
        set_win(0, 0, 0, 1);
        frame(4, 6, 14'h0500, 1, -1);
        chk("R9 embed level", 32'(fifo_level), 32'd0);
        cfg_embed_sync = 1'b0;

        // R10: disable mid-frame, frame completes, then FIFO cleared at blanking
        frame(4, 6, 14'h0600, 0, 0);
        chk("R10 frame finishes after disable", 32'(fifo_level), 32'd1);
        pixel(0, 0, 14'h3FFF, 14'h3FFF);
        chk("R10 empty after stop", 32'(fifo_empty), 32'd1);
        chk("R10 level after stop", 32'(fifo_level), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule